// File: doc/BRIEF.md
# Multiplier-Free Bit-Serial FIR Filter

This block is an eight-tap FIR filter that uses no multipliers. It takes signed 8-bit samples, keeps the eight most recent ones in a tap line, and computes each output one sample bit per clock cycle. In each cycle the bits of the same weight from all eight stored samples form an 8-bit slice. The slice is split into two 4-bit addresses. Each address selects an entry from a small table of precomputed coefficient sums.

A pre-adder combines the two table entries. A shift-and-add accumulator then builds the full product sum. The most significant bit is handled first, and its term is subtracted because it carries negative weight. The coefficients are fixed when the block is built. An upstream source offers a sample with `smp_valid` and the block takes it when `smp_ready` is high. The finished sum appears on `y_data`, marked by a one-cycle `y_valid` pulse.

Top module: `da_fir8`

## Requirements
- R1: After reset, `smp_ready` is 1, `y_valid` is 0 and `y_data` is 0. Before any sample is taken, all tap-line entries are zero.
- R2: Each accepted sample enters tap position 0 and moves every older sample one position further. The result is sum over k of COEFS[k] times the sample accepted k acceptances ago, with taps not yet filled counting as zero. COEFS[k] is the signed COEF_W-bit field at bits k*COEF_W upward.
- R3: `y_valid` is high for exactly one cycle. That cycle follows the SAMPLE_W-th rising edge after the edge that accepted the sample, so by default the result appears 8 cycles after acceptance.
- R4: `smp_ready` is low from the edge that accepts a sample until the result is produced. A `smp_valid` asserted while `smp_ready` is low is ignored: no sample is shifted in, and later results show no trace of it.
- R5: The sign bit of each sample has weight -2^(SAMPLE_W-1). With tap 0 holding 7 and tap 1 holding 5, coefficients -7 and 6 on those taps, and zero in all other taps, the result is -19.
- R6: `y_data` keeps its value between strobes, including while the next sample is being processed.
- R7: Full-scale samples (-128 and 127) combined with the extreme coefficients -128 and 127 give the exact sum without wraparound. The result is a signed ACC_W = COEF_W + log2(TAPS) + SAMPLE_W bit value, 19 bits by default.
- R8: `smp_ready` is high in the cycle where `y_valid` is high. A sample offered in that cycle is accepted, giving a throughput of one sample every SAMPLE_W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A sample is offered |
| smp_data | input | SAMPLE_W | Signed input sample |
| smp_ready | output | 1 | The block can take a sample this cycle |
| y_valid | output | 1 | One-cycle strobe marking a new result |
| y_data | output | ACC_W | Signed filter output |

## Verification
Two events can fall in the same cycle: a result is published, and the next sample is accepted, which restarts the accumulator. The bench always offers the next sample in the strobe cycle itself. It then checks that the published value was computed from the previous tap contents and stays unchanged through the following computation. It also checks that the new result comes out exactly SAMPLE_W cycles later. A separate case drives `smp_valid` during a busy cycle, and every later result is compared against a reference model in which that sample never arrived.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    // Kind of accumulator update in a given cycle
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,   // keep value
        STEP_SIGN = 2'd1,   // first (sign) bit: start from minus the term
        STEP_MAG  = 2'd2    // magnitude bit: double and add the term
    } step_e;

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
    parameter int SAMPLE_W = 8,
    parameter int TAPS     = 8,
    parameter int CNT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [CNT_W-1:0]    bit_sel,
    output logic [TAPS-1:0]     slice
);

    logic [SAMPLE_W-1:0] taps_d [TAPS];
    logic [SAMPLE_W-1:0] taps_q [TAPS];

    always_comb begin
        for (int k = 0; k < TAPS; k++) begin
            taps_d[k] = taps_q[k];
        end
        if (shift_en) begin
            taps_d[0] = sample_in;
            for (int k = 1; k < TAPS; k++) begin
                taps_d[k] = taps_q[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) begin
                taps_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < TAPS; k++) begin
                taps_q[k] <= taps_d[k];
            end
        end
    end

    // Parallel-to-serial: one bit of equal weight from every tap
    for (genvar k = 0; k < TAPS; k++) begin : g_slice
        assign slice[k] = taps_q[k][bit_sel];
    end

endmodule

// File: rtl/da_pp_table.sv
module da_pp_table #(
    parameter int                     IN     = 4,
    parameter int                     COEF_W = 8,
    parameter logic [IN*COEF_W-1:0]   COEFS  = '0,
    parameter int                     OUT_W  = COEF_W + $clog2(IN)
) (
    input  logic [IN-1:0]           addr,
    output logic signed [OUT_W-1:0] value
);

    localparam int DEPTH = 1 << IN;

    // Entry a = sum of the coefficients whose address bit is set
    function automatic logic signed [OUT_W-1:0] entry(input int a);
        logic signed [OUT_W-1:0] s;
        s = '0;
        for (int k = 0; k < IN; k++) begin
            if (a[k]) begin
                s = s + OUT_W'(signed'(COEFS[k*COEF_W +: COEF_W]));
            end
        end
        return s;
    endfunction

    logic signed [OUT_W-1:0] rom [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_rom
        assign rom[a] = entry(a);
    end

    assign value = rom[addr];

endmodule

// File: rtl/da_pre_add.sv
module da_pre_add #(
    parameter int N     = 2,
    parameter int IN_W  = 10,
    parameter int OUT_W = IN_W + $clog2(N)
) (
    input  logic signed [IN_W-1:0]  parts [N],
    output logic signed [OUT_W-1:0] sum
);

    always_comb begin
        sum = '0;
        for (int t = 0; t < N; t++) begin
            sum = sum + OUT_W'(parts[t]);
        end
    end

endmodule

// File: rtl/da_scale_acc.sv
module da_scale_acc
    import da_fir_pkg::*;
#(
    parameter int IN_W  = 11,
    parameter int ACC_W = 19
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  step_e                   step,
    input  logic signed [IN_W-1:0]  term,
    output logic signed [ACC_W-1:0] acc_next
);

    logic signed [ACC_W-1:0] acc_d;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] term_ext;

    always_comb begin
        term_ext = ACC_W'(term);
        unique case (step)
            STEP_SIGN: acc_d = -term_ext;
            STEP_MAG:  acc_d = (acc_q <<< 1) + term_ext;
            default:   acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_next = acc_d;

endmodule

// File: rtl/da_fir8.sv
module da_fir8
    import da_fir_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    parameter int TAPS     = 8,
    parameter int TBL_IN   = 4,
    parameter logic [TAPS*COEF_W-1:0] COEFS = {8'd1, 8'hC4, 8'd45, 8'd127,
                                               8'h80, 8'd23, 8'd6, 8'hF9}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_valid,
    input  logic [SAMPLE_W-1:0]          smp_data,
    output logic                         smp_ready,
    output logic                         y_valid,
    output logic [COEF_W+$clog2(TAPS)+SAMPLE_W-1:0] y_data
);

    localparam int N_TBL = TAPS / TBL_IN;
    localparam int TBL_W = COEF_W + $clog2(TBL_IN);
    localparam int SUM_W = TBL_W + $clog2(N_TBL);
    localparam int ACC_W = COEF_W + $clog2(TAPS) + SAMPLE_W;
    localparam int CNT_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] bit_idx;
        logic             out_valid;
        logic [ACC_W-1:0] out_data;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic                    accept;
    step_e                   step;
    logic [TAPS-1:0]         slice;
    logic signed [TBL_W-1:0] tbl_out [N_TBL];
    logic signed [SUM_W-1:0] pre_sum;
    logic signed [ACC_W-1:0] acc_next;

    assign accept = smp_valid && !ctrl_q.busy;

    // Control: MSB first, one bit per cycle
    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.out_valid = 1'b0;
        step             = STEP_HOLD;
        if (ctrl_q.busy) begin
            step = (ctrl_q.bit_idx == CNT_W'(SAMPLE_W-1)) ? STEP_SIGN : STEP_MAG;
            if (ctrl_q.bit_idx == '0) begin
                ctrl_d.busy      = 1'b0;
                ctrl_d.out_valid = 1'b1;
                ctrl_d.out_data  = acc_next;
            end else begin
                ctrl_d.bit_idx = ctrl_q.bit_idx - 1'b1;
            end
        end else if (accept) begin
            ctrl_d.busy    = 1'b1;
            ctrl_d.bit_idx = CNT_W'(SAMPLE_W-1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    da_tap_line #(
        .SAMPLE_W (SAMPLE_W),
        .TAPS     (TAPS),
        .CNT_W    (CNT_W)
    ) u_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (accept),
        .sample_in (smp_data),
        .bit_sel   (ctrl_q.bit_idx),
        .slice     (slice)
    );

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        da_pp_table #(
            .IN     (TBL_IN),
            .COEF_W (COEF_W),
            .COEFS  (COEFS[t*TBL_IN*COEF_W +: TBL_IN*COEF_W]),
            .OUT_W  (TBL_W)
        ) u_tbl (
            .addr  (slice[t*TBL_IN +: TBL_IN]),
            .value (tbl_out[t])
        );
    end

    da_pre_add #(
        .N     (N_TBL),
        .IN_W  (TBL_W),
        .OUT_W (SUM_W)
    ) u_pre (
        .parts (tbl_out),
        .sum   (pre_sum)
    );

    da_scale_acc #(
        .IN_W  (SUM_W),
        .ACC_W (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .term     (pre_sum),
        .acc_next (acc_next)
    );

    assign smp_ready = !ctrl_q.busy;
    assign y_valid   = ctrl_q.out_valid;
    assign y_data    = ctrl_q.out_data;

endmodule

// File: rtl/da_fir8_chk.sv
module da_fir8_chk #(
    parameter int ACC_W    = 19,
    parameter int SAMPLE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             smp_ready,
    input logic             y_valid,
    input logic [ACC_W-1:0] y_data
);

    logic       armed_q;
    logic [7:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            since_q <= '0;
        end else if (smp_valid && smp_ready) begin
            armed_q <= 1'b1;
            since_q <= '0;
        end else if (armed_q && since_q != 8'hFF) begin
            since_q <= since_q + 8'd1;
        end
    end

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |=> !y_valid);

    // R3
    strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (armed_q && since_q == 8'(SAMPLE_W)));

    // R4
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(y_data) |-> y_valid);

    // R8
    ready_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> smp_ready);

endmodule

bind da_fir8 da_fir8_chk #(
    .ACC_W    (ACC_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .y_valid   (y_valid),
    .y_data    (y_data)
);

// File: tb/sim_da_fir8.sv
module sim_da_fir8;

    localparam int SAMPLE_W = 8;
    localparam int COEF_W   = 8;
    localparam int TAPS     = 8;
    localparam int ACC_W    = 19;
    localparam int COEF [TAPS] = '{-7, 6, 23, -128, 127, 45, -60, 1};

    function automatic logic [TAPS*COEF_W-1:0] pack_coefs();
        logic [TAPS*COEF_W-1:0] p;
        for (int k = 0; k < TAPS; k++) p[k*COEF_W +: COEF_W] = COEF_W'(COEF[k]);
        return p;
    endfunction

    localparam logic [TAPS*COEF_W-1:0] COEF_PACK = pack_coefs();

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_valid = 1'b0;
    logic [SAMPLE_W-1:0] smp_data = '0;
    logic                smp_ready;
    logic                y_valid;
    logic signed [ACC_W-1:0] y_data;

    int checks = 0;
    int errors = 0;
    int hist [TAPS];
    int prev_result = 0;

    always #10 clk = ~clk;

    da_fir8 #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .TAPS     (TAPS),
        .TBL_IN   (4),
        .COEFS    (COEF_PACK)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_ready (smp_ready),
        .y_valid   (y_valid),
        .y_data    (y_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int ref_out();
        int s = 0;
        for (int k = 0; k < TAPS; k++) s += COEF[k] * hist[k];
        return s;
    endfunction

    // Called at a negedge with smp_ready expected high; returns at the strobe negedge
    task automatic send(input int sample, input bit poke, input string req);
        int  expv;
        bit  early;
        smp_valid = 1'b1;
        smp_data  = SAMPLE_W'(sample);
        @(negedge clk);
        smp_valid = 1'b0;
        for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = sample;
        expv = ref_out();
        chk(smp_ready == 1'b0, "R4 busy after take", longint'(smp_ready), 0);
        chk(y_valid == 1'b0 && int'(y_data) == prev_result, "R6 hold during next",
            longint'(y_data), longint'(prev_result));
        if (poke) begin
            smp_valid = 1'b1;
            smp_data  = 8'h63;
        end
        early = 1'b0;
        for (int i = 1; i <= SAMPLE_W; i++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            if (i < SAMPLE_W && y_valid) early = 1'b1;
        end
        chk(!early && y_valid, "R3 strobe timing", longint'(y_valid), 1);
        chk(int'(y_data) == expv, req, longint'(y_data), longint'(expv));
        chk(smp_ready == 1'b1, "R8 ready at strobe", longint'(smp_ready), 1);
        prev_result = expv;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(smp_ready == 1'b1, "R1 ready", longint'(smp_ready), 1);
        chk(y_valid == 1'b0, "R1 valid", longint'(y_valid), 0);
        chk(y_data == '0, "R1 data", longint'(y_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 impulse response: each coefficient in turn
        send(1, 1'b0, "R2 impulse");
        for (int j = 1; j < TAPS + 1; j++) send(0, 1'b0, "R2 impulse");

        // R5 two-tap signed example: tap1=5, tap0=7 gives -19
        send(5, 1'b0, "R5 sign weight");
        send(7, 1'b0, "R5 sign weight");

        // R7 full-scale, largest negative then largest positive
        for (int j = TAPS - 1; j >= 0; j--) send((COEF[j] < 0) ? 127 : -128, 1'b0, "R7 full scale");
        for (int j = TAPS - 1; j >= 0; j--) send((COEF[j] < 0) ? -128 : 127, 1'b0, "R7 full scale");
        for (int j = 0; j < TAPS; j++) send(-128, 1'b0, "R7 all min");

        // R4 offers while busy are ignored
        for (int j = 0; j < 10; j++) send(int'($signed(8'($urandom))), 1'b1, "R4 ignored offer");

        // R2 random samples
        for (int j = 0; j < 60; j++) send(int'($signed(8'($urandom))), 1'b0, "R2 random");

        @(negedge clk);
        chk(y_valid == 1'b0, "R3 single pulse", longint'(y_valid), 0);
        chk(int'(y_data) == prev_result, "R6 hold idle", longint'(y_data), longint'(prev_result));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule